// File: doc/BRIEF.md
# Always-On Real-Time Clock with Alarm

This block is a memory-mapped real-time clock. Software talks to it on a fast bus clock, while all timekeeping state (a 32-bit seconds count, a sub-second tick count, the alarm compare value, control, status and a glitch-arming word) lives in a separate slow always-on clock domain. Every accepted bus write is handed across with a toggle handshake and lands in the slow domain on the third slow edge after it is accepted. A busy output stays high until the acknowledge returns, and writes offered while it is high are dropped.

Counting is locked behind a power-up sequence with three states: init, non-valid and valid. Leaving init requires the arming word to hold 0x41736166 while the init-exit control bit is set. Leaving non-valid then requires the non-valid-exit bit and the enable bit. Each exit sets its own sticky status bit. In the valid state, a match between seconds and alarm sets an alarm flag. That flag drives an interrupt line and a separate wakeup line, each with its own enable bit.

Reads come from a bus-domain mirror of the slow registers. The mirror is refreshed only when two consecutive samples agree, so a read never returns a value that was caught mid-update.

Top module: `lp_rtc`

## Requirements
- R1: After reset every readable register reads 0, and irq, wake and busy are 0.
- R2: The block leaves init only when control bit 15 is set and the arming word at offset 0x18 equals 0x41736166. The transition sets status bit 15. Any other arming word keeps the block in init.
- R3: From non-valid the block enters valid only when control bits 14 and 3 are both set. The transition sets status bit 14. No counting happens in init or non-valid.
- R4: In the valid state with control bit 3 set, the sub-second counter at offset 0x04 advances once per slow cycle. When it wraps from all ones, the seconds counter at offset 0x00 increments modulo 2^32.
- R5: A write to offset 0x00 loads the seconds counter and clears the sub-second counter. Offset 0x04 is read-only, and a write to it changes nothing.
- R6: Writing 1 to a bit of the status register at offset 0x14 clears that bit, and writing 0 leaves it unchanged.
- R7: In the valid state, when the seconds counter equals the alarm register at offset 0x08, status bit 3 is set. The bit is set again on every slow cycle for as long as the two stay equal.
- R8: irq is high exactly when status bit 3 and control bit 7 are both set. wake is high exactly when status bit 3 and control bit 4 are both set.
- R9: busy goes high on an accepted write and stays high until the slow domain has applied it. A write presented while busy is high is ignored.
- R10: The control register at offset 0x10 keeps only bits 3, 4, 7, 11, 14 and 15, and the other bits read 0. The arming word and the alarm read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| busClk | input | 1 | Bus-side clock |
| slowClk | input | 1 | Always-on timekeeping clock |
| rstN | input | 1 | Asynchronous active-low reset for both domains |
| sel | input | 1 | Register access select |
| wr | input | 1 | Write strobe, qualified by sel |
| addr | input | 5 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data from the mirrored registers (0 when sel is low) |
| busy | output | 1 | A write is still crossing into the slow domain |
| irq | output | 1 | Alarm interrupt |
| wake | output | 1 | Alarm wakeup request |

## Verification
The embedded assertions check four things on every cycle: the state machine never skips straight from init to valid, a wrong arming word holds it in init, the sub-second count stays frozen whenever counting is off and no load arrives, and a seconds/alarm match raises the flag on the next slow edge. On the bus side, they check that a write offered while busy never starts a new transfer. Other behaviours only show up in bench scenarios: exact tick counts across a seconds wrap at 2^32, the two-step exit sequence seen through status, write-1-to-clear racing a live alarm match, the separate gating of irq and wake, and dropped writes observed through read-back.

// File: rtl/lp_rtc_pkg.sv
`timescale 1ns/1ps
package lp_rtc_pkg;
  localparam logic [4:0] OFS_SEC    = 5'h00;
  localparam logic [4:0] OFS_SUB    = 5'h04;
  localparam logic [4:0] OFS_ALARM  = 5'h08;
  localparam logic [4:0] OFS_CTRL   = 5'h10;
  localparam logic [4:0] OFS_STATUS = 5'h14;
  localparam logic [4:0] OFS_ARM    = 5'h18;

  localparam int CB_RUN     = 3;
  localparam int CB_WAKE    = 4;
  localparam int CB_IRQ     = 7;
  localparam int CB_NONSEC  = 11;
  localparam int CB_NVEXIT  = 14;
  localparam int CB_INEXIT  = 15;
  localparam logic [31:0] CTRL_KEEP = 32'h0000_C898;

  localparam int SB_ALARM  = 3;
  localparam int SB_NVDONE = 14;
  localparam int SB_INDONE = 15;
  localparam logic [31:0] STAT_KEEP = 32'h0000_C008;

  localparam logic [31:0] ARM_WORD = 32'h4173_6166;

  typedef enum logic [1:0] {PH_INIT, PH_NONVALID, PH_VALID} phase_t;

  typedef struct packed {
    logic        toSec;
    logic        toAlarm;
    logic        toCtrl;
    logic        toStatus;
    logic        toArm;
    logic [31:0] data;
  } wrReq_t;

  typedef struct packed {
    logic [31:0] sec;
    logic [31:0] sub;
    logic [31:0] alarm;
    logic [31:0] ctrl;
    logic [31:0] status;
    logic [31:0] arm;
  } regView_t;
endpackage

// File: rtl/lp_rtc_core.sv
`timescale 1ns/1ps
module lp_rtc_core
  import lp_rtc_pkg::*;
#(
  parameter int SUB_W = 15
) (
  input  logic     slowClk,
  input  logic     rstN,
  input  wrReq_t   req,
  input  logic     reqToggle,
  output logic     ackToggle,
  output regView_t view
);
  localparam int SYNC_N = 3;

  logic [SYNC_N-1:0] reqSync;
  logic              applyWr;
  phase_t            phase, phaseNext;
  logic [31:0]       secCnt, alarmReg, ctrlReg, statusReg, armReg;
  logic [31:0]       statusNext;
  logic [SUB_W-1:0]  subCnt;
  logic              countEn;

  assign applyWr   = reqSync[SYNC_N-1] ^ reqSync[SYNC_N-2];
  assign ackToggle = reqSync[SYNC_N-1];
  assign countEn   = (phase == PH_VALID) && ctrlReg[CB_RUN];

  always_comb begin
    phaseNext  = phase;
    statusNext = statusReg;
    if (applyWr && req.toStatus) statusNext = statusNext & ~req.data;
    case (phase)
      PH_INIT: if (ctrlReg[CB_INEXIT] && armReg == ARM_WORD) begin
        phaseNext = PH_NONVALID;
        statusNext[SB_INDONE] = 1'b1;
      end
      PH_NONVALID: if (ctrlReg[CB_NVEXIT] && ctrlReg[CB_RUN]) begin
        phaseNext = PH_VALID;
        statusNext[SB_NVDONE] = 1'b1;
      end
      default: ;
    endcase
    if (phase == PH_VALID && secCnt == alarmReg) statusNext[SB_ALARM] = 1'b1;
    statusNext = statusNext & STAT_KEEP;
  end

  always_ff @(posedge slowClk or negedge rstN) begin
    if (!rstN) begin
      reqSync   <= '0;
      phase     <= PH_INIT;
      secCnt    <= '0;
      subCnt    <= '0;
      alarmReg  <= '0;
      ctrlReg   <= '0;
      statusReg <= '0;
      armReg    <= '0;
    end else begin
      reqSync   <= {reqSync[SYNC_N-2:0], reqToggle};
      phase     <= phaseNext;
      statusReg <= statusNext;
      if (countEn) begin
        subCnt <= subCnt + 1'b1;
        if (&subCnt) secCnt <= secCnt + 32'd1;
      end
      if (applyWr && req.toSec) begin
        secCnt <= req.data;
        subCnt <= '0;
      end
      if (applyWr && req.toAlarm) alarmReg <= req.data;
      if (applyWr && req.toCtrl)  ctrlReg  <= req.data & CTRL_KEEP;
      if (applyWr && req.toArm)   armReg   <= req.data;
    end
  end

  always_comb begin
    view.sec    = secCnt;
    view.sub    = 32'(subCnt);
    view.alarm  = alarmReg;
    view.ctrl   = ctrlReg;
    view.status = statusReg;
    view.arm    = armReg;
  end

  // R3: no jump from init straight to valid
  a_r3_no_skip: assert property (@(posedge slowClk) disable iff (!rstN)
    phase == PH_INIT |=> phase != PH_VALID);
  // R2: a wrong arming word holds init
  a_r2_hold_init: assert property (@(posedge slowClk) disable iff (!rstN)
    (phase == PH_INIT && armReg != ARM_WORD) |=> phase == PH_INIT);
  // R4: sub-second count frozen while not counting and not loaded
  a_r4_frozen: assert property (@(posedge slowClk) disable iff (!rstN)
    (!countEn && !(applyWr && req.toSec)) |=> $stable(subCnt));
  // R7: a match raises the alarm flag
  a_r7_match_flag: assert property (@(posedge slowClk) disable iff (!rstN)
    (phase == PH_VALID && secCnt == alarmReg) |=> statusReg[SB_ALARM]);
endmodule

// File: rtl/lp_rtc_bus.sv
`timescale 1ns/1ps
module lp_rtc_bus
  import lp_rtc_pkg::*;
(
  input  logic        busClk,
  input  logic        rstN,
  input  logic        sel,
  input  logic        wr,
  input  logic [4:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        busy,
  output logic        irq,
  output logic        wake,
  input  regView_t    view,
  input  logic        ackToggle,
  output wrReq_t      req,
  output logic        reqToggle
);
  localparam int ACK_N = 2;

  logic [ACK_N-1:0] ackSync;
  logic             writable, accept;
  regView_t         sampA, sampB, mirror;

  assign busy     = reqToggle ^ ackSync[ACK_N-1];
  assign writable = (addr == OFS_SEC) || (addr == OFS_ALARM) || (addr == OFS_CTRL) ||
                    (addr == OFS_STATUS) || (addr == OFS_ARM);
  assign accept   = sel && wr && !busy && writable;

  always_ff @(posedge busClk or negedge rstN) begin
    if (!rstN) begin
      req       <= '0;
      reqToggle <= 1'b0;
      ackSync   <= '0;
      sampA     <= '0;
      sampB     <= '0;
      mirror    <= '0;
    end else begin
      ackSync <= {ackSync[ACK_N-2:0], ackToggle};
      if (accept) begin
        req.toSec    <= (addr == OFS_SEC);
        req.toAlarm  <= (addr == OFS_ALARM);
        req.toCtrl   <= (addr == OFS_CTRL);
        req.toStatus <= (addr == OFS_STATUS);
        req.toArm    <= (addr == OFS_ARM);
        req.data     <= wdata;
        reqToggle    <= ~reqToggle;
      end
      sampA <= view;
      sampB <= sampA;
      if (sampA == sampB) mirror <= sampB;
    end
  end

  always_comb begin
    rdata = '0;
    if (sel) begin
      case (addr)
        OFS_SEC:    rdata = mirror.sec;
        OFS_SUB:    rdata = mirror.sub;
        OFS_ALARM:  rdata = mirror.alarm;
        OFS_CTRL:   rdata = mirror.ctrl;
        OFS_STATUS: rdata = mirror.status;
        OFS_ARM:    rdata = mirror.arm;
        default:    rdata = '0;
      endcase
    end
  end

  assign irq  = mirror.status[SB_ALARM] & mirror.ctrl[CB_IRQ];
  assign wake = mirror.status[SB_ALARM] & mirror.ctrl[CB_WAKE];

  // R9: a write offered while busy starts nothing
  a_r9_drop_busy: assert property (@(posedge busClk) disable iff (!rstN)
    (sel && wr && busy) |=> $stable(reqToggle));
  // R9: busy only rises after a write strobe
  a_r9_busy_cause: assert property (@(posedge busClk) disable iff (!rstN)
    $rose(busy) |-> $past(sel && wr));
endmodule

// File: rtl/lp_rtc.sv
`timescale 1ns/1ps
module lp_rtc
  import lp_rtc_pkg::*;
#(
  parameter int SUB_W = 15
) (
  input  logic        busClk,
  input  logic        slowClk,
  input  logic        rstN,
  input  logic        sel,
  input  logic        wr,
  input  logic [4:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        busy,
  output logic        irq,
  output logic        wake
);
  wrReq_t   req;
  regView_t view;
  logic     reqToggle, ackToggle;

  lp_rtc_bus u_bus (
    .busClk(busClk), .rstN(rstN), .sel(sel), .wr(wr), .addr(addr), .wdata(wdata),
    .rdata(rdata), .busy(busy), .irq(irq), .wake(wake), .view(view),
    .ackToggle(ackToggle), .req(req), .reqToggle(reqToggle)
  );

  lp_rtc_core #(.SUB_W(SUB_W)) u_core (
    .slowClk(slowClk), .rstN(rstN), .req(req), .reqToggle(reqToggle),
    .ackToggle(ackToggle), .view(view)
  );
endmodule

// File: tb/lp_rtc_bench.sv
`timescale 1ns/1ps
module lp_rtc_bench;
  localparam int SUB_W = 3;
  localparam int SUB_N = 1 << SUB_W;

  logic busClk = 1'b0, slowClk = 1'b0, rstN = 1'b0;
  logic sel = 1'b0, wr = 1'b0;
  logic [4:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic busy, irq, wake;

  int checks = 0, fails = 0;
  int slowCnt = 0, acceptSlow = 0;
  bit done = 0;

  always #2 busClk = ~busClk;
  always #15 slowClk = ~slowClk;
  always @(posedge slowClk) slowCnt++;

  lp_rtc #(.SUB_W(SUB_W)) u_lp_rtc (
    .busClk(busClk), .slowClk(slowClk), .rstN(rstN), .sel(sel), .wr(wr),
    .addr(addr), .wdata(wdata), .rdata(rdata), .busy(busy), .irq(irq), .wake(wake)
  );

  function automatic logic [31:0] expCtrl(input logic [31:0] d);
    return d & 32'h0000_C898;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic settle();
    repeat (3) @(negedge busClk);
    while (busy) @(negedge busClk);
    repeat (3) @(posedge slowClk);
    repeat (6) @(negedge busClk);
  endtask

  task automatic busWrite(input logic [4:0] a, input logic [31:0] d);
    @(negedge busClk);
    while (busy) @(negedge busClk);
    sel = 1; wr = 1; addr = a; wdata = d;
    @(posedge busClk);
    acceptSlow = slowCnt;
    #1 sel = 0; wr = 0;
    settle();
  endtask

  task automatic busRead(input logic [4:0] a, output logic [31:0] d);
    @(negedge busClk);
    sel = 1; wr = 0; addr = a;
    #1 d = rdata;
    @(negedge busClk);
    sel = 0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  task automatic measureCount(input logic [31:0] startSec, input int waitSlow);
    logic [31:0] s, u, total;
    int t0, d;
    busWrite(5'h10, 32'h0000_C800);
    busWrite(5'h00, startSec);
    busRead(5'h00, s); chk("R5 sec load", s, startSec);
    busRead(5'h04, u); chk("R5 sub cleared", u, 0);
    busWrite(5'h10, 32'h0000_C808);
    t0 = acceptSlow;
    repeat (waitSlow) @(posedge slowClk);
    busWrite(5'h10, 32'h0000_C800);
    d = acceptSlow - t0;
    busRead(5'h00, s);
    busRead(5'h04, u);
    total = u + (s - startSec) * SUB_N;
    checks++;
    if (int'(total) < d - 1 || int'(total) > d + 1) begin
      fails++;
      $display("FAIL R4 tick count actual=%0d expected=%0d", total, d);
    end
  endtask

  initial begin
    #600000;
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finishRun();
  end

  initial begin
    logic [31:0] v, r;
    void'($urandom(32'd2024));
    repeat (5) @(negedge busClk);
    rstN = 1;
    repeat (4) @(posedge slowClk);
    repeat (6) @(negedge busClk);

    // R1 reset state
    for (int i = 0; i < 6; i++) begin
      logic [4:0] a;
      a = (i == 5) ? 5'h18 : (i == 4) ? 5'h14 : (i == 3) ? 5'h10 : 5'(i * 4);
      busRead(a, r); chk("R1 reset read", r, 0);
    end
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 wake", {31'b0, wake}, 0);
    chk("R1 busy", {31'b0, busy}, 0);

    busWrite(5'h08, 32'hFFFF_0000);
    // R2 no exit without arming word
    busWrite(5'h10, 32'hFFFF_FFFF);
    busRead(5'h10, r); chk("R10 ctrl mask", r, expCtrl(32'hFFFF_FFFF));
    busWrite(5'h10, 32'h0000_8800);
    busRead(5'h14, r); chk("R2 init held", r, 0);
    busWrite(5'h18, 32'h1234_5678);
    busRead(5'h18, r); chk("R10 arm readback", r, 32'h1234_5678);
    busRead(5'h14, r); chk("R2 wrong word", r, 0);
    busWrite(5'h18, 32'h4173_6166);
    busRead(5'h14, r); chk("R2 init exit", r, 32'h0000_8000);

    // R3 enable alone does not leave non-valid
    busWrite(5'h10, 32'h0000_8808);
    repeat (12) @(posedge slowClk);
    busRead(5'h14, r); chk("R3 still nonvalid", r, 32'h0000_8000);
    busRead(5'h04, r); chk("R3 no count", r, 0);
    busRead(5'h00, r); chk("R3 no seconds", r, 0);
    busWrite(5'h10, 32'h0000_C808);
    busRead(5'h14, r); chk("R3 valid", r, 32'h0000_C000);
    repeat (3 * SUB_N) @(posedge slowClk);
    busRead(5'h00, r);
    checks++;
    if (r < 2) begin fails++; $display("FAIL R4 seconds advance actual=%0d expected>=2", r); end

    // R4 counting, including 2^32 wrap
    measureCount(32'hFFFF_FFFE, 30);
    measureCount(32'hFFFF_FFFF, 9);
    for (int i = 0; i < 4; i++) measureCount($urandom & 32'h7FFF_FFFF, 5 + ($urandom % 40));

    // R5 sub-second offset is read-only
    busWrite(5'h00, 32'd77);
    busWrite(5'h04, 32'h0000_0005);
    busRead(5'h04, r); chk("R5 sub read-only", r, 0);
    busRead(5'h00, r); chk("R5 sec kept", r, 77);

    // R6 write-1-to-clear
    busWrite(5'h14, 32'h0000_8000);
    busRead(5'h14, r); chk("R6 clear bit15", r, 32'h0000_4000);
    busWrite(5'h14, 32'h0000_0000);
    busRead(5'h14, r); chk("R6 zero no effect", r, 32'h0000_4000);

    // R7/R8 alarm
    busWrite(5'h10, 32'h0000_C890);
    busWrite(5'h00, 32'd50);
    busWrite(5'h08, 32'd100);
    busRead(5'h14, r); chk("R7 no match", r, 32'h0000_4000);
    chk("R8 irq low", {31'b0, irq}, 0);
    busWrite(5'h00, 32'd100);
    busRead(5'h14, r); chk("R7 match flag", r, 32'h0000_4008);
    chk("R8 irq high", {31'b0, irq}, 1);
    chk("R8 wake high", {31'b0, wake}, 1);
    busWrite(5'h10, 32'h0000_C880);
    chk("R8 irq only", {30'b0, irq, wake}, 32'd2);
    busWrite(5'h10, 32'h0000_C810);
    chk("R8 wake only", {30'b0, irq, wake}, 32'd1);
    busWrite(5'h14, 32'h0000_0008);
    busRead(5'h14, r); chk("R7 flag re-set while equal", r, 32'h0000_4008);
    busWrite(5'h08, 32'd200);
    busWrite(5'h14, 32'h0000_0008);
    busRead(5'h14, r); chk("R6 alarm cleared", r, 32'h0000_4000);
    chk("R8 both low", {30'b0, irq, wake}, 0);

    // R9 write while busy dropped
    @(negedge busClk);
    while (busy) @(negedge busClk);
    sel = 1; wr = 1; addr = 5'h08; wdata = 32'h111;
    @(negedge busClk);
    chk("R9 busy raised", {31'b0, busy}, 1);
    wdata = 32'h222;
    @(negedge busClk);
    sel = 0; wr = 0;
    settle();
    busRead(5'h08, r); chk("R9 second write dropped", r, 32'h111);

    // random read-back
    for (int i = 0; i < 6; i++) begin
      v = $urandom;
      busWrite(5'h18, v); busRead(5'h18, r); chk("R10 arm random", r, v);
      v = $urandom;
      busWrite(5'h08, v); busRead(5'h08, r); chk("R10 alarm random", r, v);
      v = $urandom & 32'h7FFF_FFFF;
      busWrite(5'h00, v); busRead(5'h00, r); chk("R5 sec random", r, v);
      v = $urandom & 32'hFFFF_FFF7;
      busWrite(5'h10, v); busRead(5'h10, r); chk("R10 ctrl random", r, expCtrl(v));
    end

    finishRun();
  end
endmodule